// File: doc/BRIEF.md
# Attribute Text-Mode Pixel Renderer

This block converts the pixel position and blanking flags from a video timing generator into 24-bit RGB pixels for a character-cell text screen. For each cell it fetches a 16-bit entry from an external character buffer. The low byte of the entry is a character code and the high byte is a colour attribute. The code and the row within the glyph form the address of an external 8x16 font ROM. The returned byte is shifted out one pixel per clock, and each bit picks the foreground or the background colour from a fixed 16-entry CGA palette.

The text grid is 80 columns wide and is centred in a 720-pixel active line. It has 25 rows in the 480-line mode and 32 rows in the 576-line mode. Active pixels outside the grid take a border colour supplied on an input.

The character buffer and the font ROM are both synchronous, with one clock of read latency each. The block delays the blanking, sync and position-derived signals to match them, so that the pixel, data-enable and sync outputs leave together three clocks after their inputs.

Top module: `txt_pixel_render`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it falls, `rgb_out`, `de_out`, `hsync_out` and `vsync_out` are all zero.
- R2: `de_out`, `hsync_out` and `vsync_out` equal `pix_de`, `hsync_in` and `vsync_in` delayed by exactly three clock edges. The `rgb_out` value for a pixel appears on the same edge as its `de_out`.
- R3: A pixel presented with `pix_de` low comes out as `rgb_out` = 0x000000.
- R4: The text grid covers x from 40 to 679. In mode 0 (`mode_tall`=0) it covers y from 40 to 439, which is 25 rows. In mode 1 it covers y from 32 to 543, which is 32 rows. An active pixel outside the grid comes out as the `border_rgb` value present on the clock edge that registers that pixel's output.
- R5: `buf_addr` is combinational from `pix_x`/`pix_y` in the same cycle. It equals row*80 + column, where column = (x-40)/8 and row = (y-top)/16. The buffer returns `buf_data` on the next clock.
- R6: One cycle after `buf_addr`, `rom_addr` = code*16 + glyph row. The code is `buf_data[7:0]` and the glyph row is (y-top) mod 16. The ROM returns `rom_data` on the next clock.
- R7: The glyph byte is taken on the first pixel of each cell, where (x-40) mod 8 = 0. Bit 7 is the leftmost pixel, and each later pixel uses the next lower bit.
- R8: A glyph bit of 1 selects the palette entry in attribute bits 11:8 of the buffer entry. A bit of 0 selects the entry in bits 15:12.
- R9: Palette entry i has red = 0xAA·i[2] + 0x55·i[3], green = 0xAA·i[1] + 0x55·i[3] and blue = 0xAA·i[0] + 0x55·i[3]. The one exception is entry 6, whose green is 0x55, which gives 0xAA5500.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_tall | input | 1 | 0: 480-line raster with 25 rows; 1: 576-line raster with 32 rows |
| pix_x | input | 10 | Active pixel column |
| pix_y | input | 10 | Active line number |
| pix_de | input | 1 | Pixel is inside the active raster |
| hsync_in | input | 1 | Horizontal sync from the timing source |
| vsync_in | input | 1 | Vertical sync from the timing source |
| border_rgb | input | 24 | Colour for active pixels outside the text grid |
| buf_addr | output | 12 | Character buffer read address |
| buf_data | input | 16 | Buffer entry, one clock after `buf_addr` |
| rom_addr | output | 12 | Font ROM read address |
| rom_data | input | 8 | Glyph row, one clock after `rom_addr` |
| rgb_out | output | 24 | Pixel colour, 8 bits each of R, G, B (red high) |
| de_out | output | 1 | Delayed data enable |
| hsync_out | output | 1 | Delayed horizontal sync |
| vsync_out | output | 1 | Delayed vertical sync |

## Verification
Two functions can act in the same cycle: reloading the shifter with a new glyph byte at a cell boundary, and switching between the grid and the border at the grid edges. The bench provokes this with spans that start eight pixels before the left edge, that run from the last column into the right margin, and that start on the last text row. Every pixel of each span is compared with a colour computed from the buffer image, the font function and the palette formula. A wrong load phase, a stale attribute or a misaligned border flag therefore shows up on the exact pixel where it occurs.

// File: rtl/txt_pkg.sv
package txt_pkg;

   // Side-band signals carried down the pipeline next to the pixel data.
   typedef struct packed {
      logic de;
      logic hs;
      logic vs;
      logic text;
      logic load;
   } side_t;

   // One colour channel of the 16-entry palette: a base level plus an intensity lift.
   function automatic logic [7:0] pal_level(input logic base, input logic bright);
      logic [7:0] lvl;
      lvl = base ? 8'hAA : 8'h00;
      if (bright) lvl = lvl + 8'h55;
      return lvl;
   endfunction

endpackage

// File: rtl/txt_addr_gen.sv
module txt_addr_gen #(
   parameter int XW      = 10,
   parameter int COLS    = 80,
   parameter int GW      = 8,
   parameter int GH      = 16,
   parameter int X0      = 40,
   parameter int Y0_S    = 40,
   parameter int ROWS_S  = 25,
   parameter int Y0_T    = 32,
   parameter int ROWS_T  = 32,
   parameter int BUF_AW  = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   mode_tall,
   input  logic [XW-1:0]          pix_x,
   input  logic [XW-1:0]          pix_y,
   output logic [BUF_AW-1:0]      buf_addr,
   output logic                   in_text,
   output logic [$clog2(GH)-1:0]  glyph_row,
   output logic                   cell_start
);
   localparam int GWB = $clog2(GW);
   localparam int GHB = $clog2(GH);
   localparam logic [XW-1:0] X_LO   = XW'(X0);
   localparam logic [XW-1:0] X_HI   = XW'(X0 + COLS * GW);
   localparam logic [XW-1:0] YL_S   = XW'(Y0_S);
   localparam logic [XW-1:0] YH_S   = XW'(Y0_S + ROWS_S * GH);
   localparam logic [XW-1:0] YL_T   = XW'(Y0_T);
   localparam logic [XW-1:0] YH_T   = XW'(Y0_T + ROWS_T * GH);
   localparam logic [BUF_AW-1:0] COLS_A = BUF_AW'(COLS);
   localparam logic [BUF_AW-1:0] LIM_S  = BUF_AW'(COLS * ROWS_S);
   localparam logic [BUF_AW-1:0] LIM_T  = BUF_AW'(COLS * ROWS_T);

   logic [XW-1:0] y_lo, y_hi, x_rel, y_rel;
   logic [XW-GWB-1:0] col_idx;
   logic [XW-GHB-1:0] row_idx;

   always_comb begin
      y_lo    = mode_tall ? YL_T : YL_S;
      y_hi    = mode_tall ? YH_T : YH_S;
      x_rel   = pix_x - X_LO;
      y_rel   = pix_y - y_lo;
      col_idx = x_rel[XW-1:GWB];
      row_idx = y_rel[XW-1:GHB];
      in_text = (pix_x >= X_LO) && (pix_x < X_HI) && (pix_y >= y_lo) && (pix_y < y_hi);
      buf_addr   = BUF_AW'(row_idx) * COLS_A + BUF_AW'(col_idx);
      glyph_row  = y_rel[GHB-1:0];
      cell_start = (x_rel[GWB-1:0] == '0);
   end

   // R5: every in-grid address lands inside the buffer region of the current mode
   p_addr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_text |-> (buf_addr < (mode_tall ? LIM_T : LIM_S)));

endmodule

// File: rtl/txt_glyph_shift.sv
module txt_glyph_shift #(
   parameter int GW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [GW-1:0] rom_byte,
   output logic          pix_bit
);
   logic [GW-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    sh_q <= '0;
      else if (load) sh_q <= rom_byte << 1;
      else           sh_q <= sh_q << 1;
   end

   // The first pixel of a cell bypasses the register so that no clock is lost.
   assign pix_bit = load ? rom_byte[GW-1] : sh_q[GW-1];

   // R7: the pixel after a load shows the next lower bit of the loaded byte
   p_second_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(load) && !load) |-> (pix_bit == $past(rom_byte[GW-2])));

endmodule

// File: rtl/txt_colour_sel.sv
module txt_colour_sel
   import txt_pkg::*;
#(
   parameter bit BROWN6 = 1'b1
) (
   input  logic [7:0]  attr,
   input  logic        pix_bit,
   input  logic        in_text,
   input  logic        de,
   input  logic [23:0] border_rgb,
   output logic [23:0] rgb
);
   logic [3:0] idx;
   logic [7:0] red, grn, blu;

   always_comb begin
      idx = pix_bit ? attr[3:0] : attr[7:4];
      red = pal_level(idx[2], idx[3]);
      blu = pal_level(idx[0], idx[3]);
   end

   generate
      if (BROWN6) begin : g_brown
         always_comb grn = (idx == 4'd6) ? 8'h55 : pal_level(idx[1], idx[3]);
      end else begin : g_plain
         always_comb grn = pal_level(idx[1], idx[3]);
      end
   endgenerate

   always_comb begin
      if (!de)          rgb = 24'h000000;
      else if (!in_text) rgb = border_rgb;
      else              rgb = {red, grn, blu};
   end

endmodule

// File: rtl/txt_pixel_render.sv
module txt_pixel_render
   import txt_pkg::*;
#(
   parameter int XW          = 10,
   parameter int COLS        = 80,
   parameter int GLYPH_W     = 8,
   parameter int GLYPH_H     = 16,
   parameter int ACT_W       = 720,
   parameter int ACT_H_SHORT = 480,
   parameter int ROWS_SHORT  = 25,
   parameter int ACT_H_TALL  = 576,
   parameter int ROWS_TALL   = 32,
   parameter bit BROWN6      = 1'b1,
   localparam int BUF_AW     = $clog2(COLS * ROWS_TALL),
   localparam int GRW        = $clog2(GLYPH_H),
   localparam int ROM_AW     = 8 + GRW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_tall,
   input  logic [XW-1:0]     pix_x,
   input  logic [XW-1:0]     pix_y,
   input  logic              pix_de,
   input  logic              hsync_in,
   input  logic              vsync_in,
   input  logic [23:0]       border_rgb,
   output logic [BUF_AW-1:0] buf_addr,
   input  logic [15:0]       buf_data,
   output logic [ROM_AW-1:0] rom_addr,
   input  logic [7:0]        rom_data,
   output logic [23:0]       rgb_out,
   output logic              de_out,
   output logic              hsync_out,
   output logic              vsync_out
);
   localparam int X0   = (ACT_W - COLS * GLYPH_W) / 2;
   localparam int Y0_S = (ACT_H_SHORT - ROWS_SHORT * GLYPH_H) / 2;
   localparam int Y0_T = (ACT_H_TALL - ROWS_TALL * GLYPH_H) / 2;

   generate
      if (GLYPH_W != 8)                        begin : g_chk_w  $error("glyph width must match the ROM byte"); end
      if ((1 << GRW) != GLYPH_H)               begin : g_chk_h  $error("glyph height must be a power of two"); end
      if (COLS * GLYPH_W > ACT_W)              begin : g_chk_x  $error("text grid wider than active line"); end
      if (ROWS_SHORT * GLYPH_H > ACT_H_SHORT)  begin : g_chk_ys $error("short grid taller than raster"); end
      if (ROWS_TALL * GLYPH_H > ACT_H_TALL)    begin : g_chk_yt $error("tall grid taller than raster"); end
      if ((1 << XW) <= ACT_W || (1 << XW) <= ACT_H_TALL) begin : g_chk_xw $error("coordinate width too small"); end
   endgenerate

   // Stage 0: position decode, buffer address straight from the inputs.
   logic           text0, cell0;
   logic [GRW-1:0] grow0;
   side_t          s0, s1, s2;

   txt_addr_gen #(
      .XW(XW), .COLS(COLS), .GW(GLYPH_W), .GH(GLYPH_H), .X0(X0),
      .Y0_S(Y0_S), .ROWS_S(ROWS_SHORT), .Y0_T(Y0_T), .ROWS_T(ROWS_TALL), .BUF_AW(BUF_AW)
   ) i_addr (
      .clk(clk), .rst_n(rst_n), .mode_tall(mode_tall), .pix_x(pix_x), .pix_y(pix_y),
      .buf_addr(buf_addr), .in_text(text0), .glyph_row(grow0), .cell_start(cell0)
   );

   always_comb s0 = '{de: pix_de, hs: hsync_in, vs: vsync_in, text: text0, load: cell0};

   // Stage 1: buffer data arrives; font address formed from it.
   // Stage 2: glyph byte arrives; attribute held to meet it.
   logic [GRW-1:0] grow1;
   logic [7:0]     attr2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1    <= '0;
         s2    <= '0;
         grow1 <= '0;
         attr2 <= '0;
      end else begin
         s1    <= s0;
         grow1 <= grow0;
         s2    <= s1;
         attr2 <= buf_data[15:8];
      end
   end

   assign rom_addr = {buf_data[7:0], grow1};

   logic        pix_bit;
   logic [23:0] rgb_next;

   txt_glyph_shift #(.GW(GLYPH_W)) i_shift (
      .clk(clk), .rst_n(rst_n), .load(s2.load), .rom_byte(rom_data), .pix_bit(pix_bit)
   );

   txt_colour_sel #(.BROWN6(BROWN6)) i_colour (
      .attr(attr2), .pix_bit(pix_bit), .in_text(s2.text), .de(s2.de),
      .border_rgb(border_rgb), .rgb(rgb_next)
   );

   // Stage 3: output register.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rgb_out   <= '0;
         de_out    <= 1'b0;
         hsync_out <= 1'b0;
         vsync_out <= 1'b0;
      end else begin
         rgb_out   <= rgb_next;
         de_out    <= s2.de;
         hsync_out <= s2.hs;
         vsync_out <= s2.vs;
      end
   end

   // Cycles since reset, saturating; keeps the lag checks inside the reset history.
   logic [1:0] warm;
   always_ff @(posedge clk) begin
      if (!rst_n)              warm <= 2'd0;
      else if (warm != 2'd3)   warm <= warm + 2'd1;
   end

   p_hsync_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3) |-> (hsync_out == $past(hsync_in, 3)));
   p_de_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3) |-> (de_out == $past(pix_de, 3)));
   p_blank_black_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !s2.de |=> (rgb_out == 24'h000000));
   p_border_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (s2.de && !s2.text) |=> (rgb_out == $past(border_rgb)));

endmodule

// File: tb/test_txt_pixel_render.sv
`timescale 1ns/1ps
module test_txt_pixel_render;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        mode_tall;
   logic [9:0]  pix_x, pix_y;
   logic        pix_de, hsync_in, vsync_in;
   logic [23:0] border_rgb;
   logic [11:0] buf_addr, rom_addr;
   logic [15:0] buf_data;
   logic [7:0]  rom_data;
   logic [23:0] rgb_out;
   logic        de_out, hsync_out, vsync_out;

   always #5 clk = ~clk;

   txt_pixel_render i_txt_pixel_render (
      .clk(clk), .rst_n(rst_n), .mode_tall(mode_tall), .pix_x(pix_x), .pix_y(pix_y),
      .pix_de(pix_de), .hsync_in(hsync_in), .vsync_in(vsync_in), .border_rgb(border_rgb),
      .buf_addr(buf_addr), .buf_data(buf_data), .rom_addr(rom_addr), .rom_data(rom_data),
      .rgb_out(rgb_out), .de_out(de_out), .hsync_out(hsync_out), .vsync_out(vsync_out)
   );

   // Synchronous buffer and font models.
   logic [15:0] vram [0:2559];
   function automatic logic [7:0] font_f(input logic [11:0] a);
      return a[11:4] ^ {a[3:0], ~a[3:0]} ^ 8'h3C;
   endfunction
   always_ff @(posedge clk) buf_data <= (buf_addr < 12'd2560) ? vram[buf_addr] : 16'h0000;
   always_ff @(posedge clk) rom_data <= font_f(rom_addr);

   localparam logic [23:0] PAL [16] = '{
      24'h000000, 24'h0000AA, 24'h00AA00, 24'h00AAAA,
      24'hAA0000, 24'hAA00AA, 24'hAA5500, 24'hAAAAAA,
      24'h555555, 24'h5555FF, 24'h55FF55, 24'h55FFFF,
      24'hFF5555, 24'hFF55FF, 24'hFFFF55, 24'hFFFFFF };

   // {mode, y, x0, length}; every span starts on a cell boundary.
   localparam int NV = 12;
   localparam logic [28:0] VEC [NV] = '{
      {1'b0, 10'd40,  10'd40,  8'd16},
      {1'b0, 10'd55,  10'd672, 8'd16},
      {1'b0, 10'd439, 10'd32,  8'd24},
      {1'b0, 10'd440, 10'd40,  8'd8},
      {1'b0, 10'd39,  10'd200, 8'd8},
      {1'b1, 10'd543, 10'd360, 8'd16},
      {1'b1, 10'd32,  10'd0,   8'd48},
      {1'b1, 10'd544, 10'd40,  8'd8},
      {1'b1, 10'd300, 10'd496, 8'd24},
      {1'b0, 10'd200, 10'd704, 8'd16},
      {1'b0, 10'd32,  10'd40,  8'd8},
      {1'b1, 10'd439, 10'd40,  8'd16} };

   int n_chk = 0, n_bad = 0, nstep = 0;
   logic [23:0] h_rgb [4];
   logic        h_de [4], h_hs [4], h_vs [4], h_ok [4];
   string       h_req [4];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_hist();
      for (int i = 0; i < 4; i++) h_ok[i] = 1'b0;
   endtask

   task automatic step(input logic m, input int x, input int y, input logic de);
      int yl, yh, col, row, gr, ent_i, slot;
      logic [15:0] ent;
      logic [7:0]  g;
      logic        hs, vs, intext;
      @(negedge clk);
      slot = (nstep + 1) % 4;
      if (h_ok[slot]) begin
         chk(h_req[slot], {8'h0, rgb_out}, {8'h0, h_rgb[slot]});
         chk("R2 sync/de lag", {29'h0, de_out, hsync_out, vsync_out},
             {29'h0, h_de[slot], h_hs[slot], h_vs[slot]});
      end
      hs = ((nstep / 4) % 2) == 1;
      vs = (nstep % 3) == 0;
      yl = m ? 32 : 40;
      yh = m ? 544 : 440;
      intext = (x >= 40) && (x < 680) && (y >= yl) && (y < yh);
      slot = nstep % 4;
      h_ok[slot] = 1'b1;
      h_de[slot] = de; h_hs[slot] = hs; h_vs[slot] = vs;
      if (!de) begin
         h_rgb[slot] = 24'h0; h_req[slot] = "R3 blank pixel";
      end else if (!intext) begin
         h_rgb[slot] = border_rgb; h_req[slot] = "R4 border pixel";
      end else begin
         col = (x - 40) / 8; row = (y - yl) / 16; gr = (y - yl) % 16;
         ent_i = row * 80 + col;
         ent = vram[ent_i];
         g = font_f({ent[7:0], 4'(gr)});
         h_rgb[slot] = g[7 - ((x - 40) % 8)] ? PAL[ent[11:8]] : PAL[ent[15:12]];
         h_req[slot] = "R6 R7 R8 R9 text pixel";
      end
      mode_tall = m; pix_x = 10'(x); pix_y = 10'(y); pix_de = de;
      hsync_in = hs; vsync_in = vs;
      #1;
      if (de && intext) chk("R5 buffer address", {20'h0, buf_addr}, 32'(ent_i));
      nstep++;
   endtask

   task automatic flush();
      for (int i = 0; i < 3; i++) step(1'b0, 0, 0, 1'b0);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog R1 R2 actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 2560; i++) vram[i] = {8'(i * 37 + 5), 8'(i * 11 + 33)};
      vram[5 * 80 + 10] = 16'h6E41;   // background entry 6, foreground entry 14
      vram[0]           = 16'h7800;   // background entry 7, foreground entry 8
      clear_hist();
      rst_n = 1'b0; mode_tall = 1'b0; pix_x = '0; pix_y = '0; pix_de = 1'b0;
      hsync_in = 1'b1; vsync_in = 1'b1; border_rgb = 24'h123456;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 reset outputs", {5'h0, rgb_out, de_out, hsync_out, vsync_out}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // Table walk
      for (int v = 0; v < NV; v++) begin
         flush();
         border_rgb = 24'h102030 * 24'(v + 1);
         for (int p = 0; p < int'(VEC[v][7:0]); p++)
            step(VEC[v][28], int'(VEC[v][17:8]) + p, int'(VEC[v][27:18]), 1'b1);
      end

      // R9: brown and bright entries in one cell (row 5, column 10, mode 0)
      flush();
      border_rgb = 24'hFEDCBA;
      for (int p = 0; p < 8; p++) step(1'b0, 120 + p, 40 + 5 * 16 + 3, 1'b1);
      // R8 R9: cell 0 of every glyph row in mode 0
      for (int r = 0; r < 16; r++) begin
         flush();
         for (int p = 0; p < 8; p++) step(1'b0, 40 + p, 40 + r, 1'b1);
      end

      // R3: blanked pixels over the text grid stay black
      flush();
      for (int p = 0; p < 16; p++) step(1'b0, 40 + p, 100, 1'b0);
      // R3: blank/active alternation inside one cell run
      for (int p = 0; p < 16; p++) step(1'b1, 80 + p, 200, (p % 8) < 8 && p >= 8);
      flush();

      // R1: reset in the middle of a text run
      for (int p = 0; p < 8; p++) step(1'b0, 48 + p, 60, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset mid-run", {5'h0, rgb_out, de_out, hsync_out, vsync_out}, 32'h0);
      clear_hist();
      rst_n = 1'b1;
      flush();
      for (int p = 0; p < 8; p++) step(1'b1, 40 + p, 32, 1'b1);
      flush();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule